// File: doc/BRIEF.md
# Dispatch Credit and Admission Limiter

This block sits beside a rename stage and decides, every cycle, how many of the instructions waiting at rename may move on. It holds the most recent free-slot counts that the reorder buffer, the issue queue and the load/store queue have reported. Those counts arrive late, so the block keeps its own count of instructions that have been admitted but not yet dispatched. It rebuilds a live credit for each queue from the reported count, the in-flight count and this cycle's dispatch count. The load/store queue uses its own dispatch count for this.

The tightest of the three credits bounds admission. The rename width and the supply of free physical registers for the head instruction bound it further. When admission falls short of what is waiting, the block raises a block request towards the earlier stages. When a queue is what limits admission, the block reports that queue with a one-hot reason code and counts the event in a saturating counter for that queue. All results are registered and appear one clock after the inputs that produced them.

Top module: `dispatch_credit_limiter`

## Requirements
- R1: After a synchronous reset, admitted count, block request, reason code, the three event counters, the in-flight count and the three stored free counts are all zero, and the stored queue-empty flag is 1.
- R2: A stored free count loads only in a cycle whose valid strobe is high. The queue-empty flag loads with the reorder-buffer strobe. A loaded value is first used for credit in the following cycle, and a value offered without its strobe has no effect.
- R3: Reorder-buffer credit and issue-queue credit are each the stored count minus (in-flight minus total dispatched this cycle). Load/store-queue credit is the stored count minus (in-flight minus load/store dispatched this cycle). Credits are signed and may be negative.
- R4: The limiting queue has the smallest credit. Ties go to the reorder buffer first, then the issue queue, then the load/store queue. The reason code is one-hot with bit 0 for the reorder buffer, bit 1 for the issue queue and bit 2 for the load/store queue, and it is nonzero only when admission is credit-limited.
- R5: With instructions waiting and a smallest credit of zero or less, nothing is admitted, block is raised, the reason names the limiting queue and its event counter increments.
- R6: With a positive smallest credit below the waiting count, admission is capped at that credit, block is raised, the reason is reported and the counter increments.
- R7: Admission never exceeds the rename width. Any waiting instruction left unadmitted raises block.
- R8: With instructions waiting and fewer free physical registers than the head instruction's destination count, nothing is admitted and block is raised.
- R9: The in-flight count gains the admitted count and loses the total dispatched count each cycle, and it is held at zero rather than going below.
- R10: With no instructions waiting, nothing is admitted, block is low, the reason is zero and no counter moves.
- R11: Each event counter stops at its all-ones value.
- R12: Admitted count, block and reason reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rob_free_in | input | FREE_W | Reported reorder-buffer free entries |
| rob_free_vld | input | 1 | Strobe for rob_free_in and rob_empty_in |
| rob_empty_in | input | 1 | Reported reorder-buffer empty flag |
| iq_free_in | input | FREE_W | Reported issue-queue free entries |
| iq_free_vld | input | 1 | Strobe for iq_free_in |
| lsq_free_in | input | FREE_W | Reported load/store-queue free entries |
| lsq_free_vld | input | 1 | Strobe for lsq_free_in |
| disp_all | input | AVAIL_W | Instructions dispatched this cycle |
| disp_lsq | input | AVAIL_W | Instructions dispatched to the load/store queue this cycle |
| avail_cnt | input | AVAIL_W | Instructions waiting at rename |
| rename_width | input | AVAIL_W | Maximum instructions admitted per cycle |
| free_pregs | input | PREG_W | Free physical registers |
| head_dests | input | DEST_W | Destination registers of the head instruction |
| adm_cnt | output | AVAIL_W | Instructions admitted |
| block_req | output | 1 | Block request to earlier stages |
| full_reason | output | 3 | One-hot limiting queue |
| rob_empty | output | 1 | Stored reorder-buffer empty flag |
| rob_full_evt | output | EVT_W | Reorder-buffer-limited events |
| iq_full_evt | output | EVT_W | Issue-queue-limited events |
| lsq_full_evt | output | EVT_W | Load/store-queue-limited events |

## Verification
The bench builds the block with a three-bit event counter, so saturation is reached after seven limited cycles rather than tens of thousands. A five-bit free count and a four-bit waiting count let waiting instructions often exceed credit, and let stale reports drive credits negative within a few cycles. A four-bit physical register count makes register starvation common in the random phase. Directed steps set up exact ties, a report offered without its strobe, and a dispatch larger than the in-flight count.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  localparam int NUM_RES = 3;

  typedef enum int unsigned {
    RES_ROB = 0,
    RES_IQ  = 1,
    RES_LSQ = 2
  } res_e;

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/dcl_credit_unit.sv
module dcl_credit_unit #(
  parameter int FREE_W   = 6,
  parameter int FLIGHT_W = 7,
  parameter int DISP_W   = 4,
  parameter int CRED_W   = 9
) (
  input  logic [FREE_W-1:0]        free_cnt,
  input  logic [FLIGHT_W-1:0]      inflight,
  input  logic [DISP_W-1:0]        disp_now,
  output logic signed [CRED_W-1:0] credit
);
  logic signed [CRED_W-1:0] f_s, i_s, d_s;

  always_comb begin
    f_s    = $signed({{(CRED_W-FREE_W){1'b0}}, free_cnt});
    i_s    = $signed({{(CRED_W-FLIGHT_W){1'b0}}, inflight});
    d_s    = $signed({{(CRED_W-DISP_W){1'b0}}, disp_now});
    credit = f_s - (i_s - d_s);
  end
endmodule

// File: rtl/dcl_min_select.sv
module dcl_min_select #(
  parameter int N      = 3,
  parameter int CRED_W = 9
) (
  input  logic [N-1:0][CRED_W-1:0] cred,
  output logic signed [CRED_W-1:0] min_cred,
  output logic [N-1:0]             min_onehot
);
  always_comb begin
    int best;
    best     = 0;
    min_cred = $signed(cred[0]);
    for (int i = 1; i < N; i++) begin
      if ($signed(cred[i]) < min_cred) begin
        min_cred = $signed(cred[i]);
        best     = i;
      end
    end
    min_onehot       = '0;
    min_onehot[best] = 1'b1;
  end
endmodule

// File: rtl/dcl_admit_ctrl.sv
module dcl_admit_ctrl #(
  parameter int CRED_W  = 9,
  parameter int AVAIL_W = 4,
  parameter int PREG_W  = 8,
  parameter int DEST_W  = 2
) (
  input  logic signed [CRED_W-1:0] min_cred,
  input  logic [AVAIL_W-1:0]       avail,
  input  logic [AVAIL_W-1:0]       width,
  input  logic [PREG_W-1:0]        free_pregs,
  input  logic [DEST_W-1:0]        head_dests,
  output logic [AVAIL_W-1:0]       admit,
  output logic                     block,
  output logic                     limited
);
  logic signed [CRED_W-1:0] avail_s;
  logic [PREG_W-1:0]        dests_ext;
  logic                     nonpos;

  always_comb begin
    avail_s   = $signed({{(CRED_W-AVAIL_W){1'b0}}, avail});
    dests_ext = {{(PREG_W-DEST_W){1'b0}}, head_dests};
    nonpos    = min_cred[CRED_W-1] || (min_cred == '0);
    admit     = '0;
    block     = 1'b0;
    limited   = 1'b0;
    if (avail != '0) begin
      if (nonpos) begin
        limited = 1'b1;
        admit   = '0;
      end else begin
        admit = avail;
        if (min_cred < avail_s) begin
          admit   = min_cred[AVAIL_W-1:0];
          limited = 1'b1;
        end
        if (admit > width) admit = width;
      end
      if (free_pregs < dests_ext) admit = '0;
      if (limited || (admit < avail)) block = 1'b1;
    end
  end
endmodule

// File: rtl/dcl_sat_counter.sv
module dcl_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (inc && (cnt != '1)) cnt <= cnt + ONE;
  end
endmodule

// File: rtl/dispatch_credit_limiter.sv
module dispatch_credit_limiter
  import dcl_pkg::*;
#(
  parameter int FREE_W   = 6,
  parameter int FLIGHT_W = 7,
  parameter int AVAIL_W  = 4,
  parameter int PREG_W   = 8,
  parameter int DEST_W   = 2,
  parameter int EVT_W    = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FREE_W-1:0]  rob_free_in,
  input  logic               rob_free_vld,
  input  logic               rob_empty_in,
  input  logic [FREE_W-1:0]  iq_free_in,
  input  logic               iq_free_vld,
  input  logic [FREE_W-1:0]  lsq_free_in,
  input  logic               lsq_free_vld,
  input  logic [AVAIL_W-1:0] disp_all,
  input  logic [AVAIL_W-1:0] disp_lsq,
  input  logic [AVAIL_W-1:0] avail_cnt,
  input  logic [AVAIL_W-1:0] rename_width,
  input  logic [PREG_W-1:0]  free_pregs,
  input  logic [DEST_W-1:0]  head_dests,
  output logic [AVAIL_W-1:0] adm_cnt,
  output logic               block_req,
  output logic [2:0]         full_reason,
  output logic               rob_empty,
  output logic [EVT_W-1:0]   rob_full_evt,
  output logic [EVT_W-1:0]   iq_full_evt,
  output logic [EVT_W-1:0]   lsq_full_evt
);
  localparam int CRED_W = max3(FREE_W, FLIGHT_W, AVAIL_W) + 2;
  localparam int NXT_W  = ((FLIGHT_W > AVAIL_W) ? FLIGHT_W : AVAIL_W) + 2;

  logic [NUM_RES-1:0][FREE_W-1:0]  rpt_val;
  logic [NUM_RES-1:0]              rpt_vld;
  logic [NUM_RES-1:0][FREE_W-1:0]  free_q;
  logic [NUM_RES-1:0][AVAIL_W-1:0] res_disp;
  logic [NUM_RES-1:0][CRED_W-1:0]  cred_all;
  logic [NUM_RES-1:0][EVT_W-1:0]   evt_cnt;
  logic [NUM_RES-1:0]              min_onehot;
  logic signed [CRED_W-1:0]        min_cred;
  logic [FLIGHT_W-1:0]             inflight_q;
  logic [FLIGHT_W-1:0]             inflight_nxt;
  logic signed [NXT_W-1:0]         nxt_s;
  logic [AVAIL_W-1:0]              adm_c;
  logic                            blk_c;
  logic                            lim_c;

  always_comb begin
    rpt_val[RES_ROB] = rob_free_in;
    rpt_val[RES_IQ]  = iq_free_in;
    rpt_val[RES_LSQ] = lsq_free_in;
    rpt_vld[RES_ROB] = rob_free_vld;
    rpt_vld[RES_IQ]  = iq_free_vld;
    rpt_vld[RES_LSQ] = lsq_free_vld;
  end

  for (genvar r = 0; r < NUM_RES; r++) begin : g_res
    if (r == int'(RES_LSQ)) begin : g_lsq_disp
      assign res_disp[r] = disp_lsq;
    end else begin : g_all_disp
      assign res_disp[r] = disp_all;
    end

    dcl_credit_unit #(
      .FREE_W(FREE_W), .FLIGHT_W(FLIGHT_W), .DISP_W(AVAIL_W), .CRED_W(CRED_W)
    ) u_cred (
      .free_cnt(free_q[r]),
      .inflight(inflight_q),
      .disp_now(res_disp[r]),
      .credit  (cred_all[r])
    );

    dcl_sat_counter #(.W(EVT_W)) u_evt (
      .clk(clk),
      .rst(rst),
      .inc(lim_c && min_onehot[r]),
      .cnt(evt_cnt[r])
    );
  end

  dcl_min_select #(.N(NUM_RES), .CRED_W(CRED_W)) u_min (
    .cred      (cred_all),
    .min_cred  (min_cred),
    .min_onehot(min_onehot)
  );

  dcl_admit_ctrl #(
    .CRED_W(CRED_W), .AVAIL_W(AVAIL_W), .PREG_W(PREG_W), .DEST_W(DEST_W)
  ) u_adm (
    .min_cred  (min_cred),
    .avail     (avail_cnt),
    .width     (rename_width),
    .free_pregs(free_pregs),
    .head_dests(head_dests),
    .admit     (adm_c),
    .block     (blk_c),
    .limited   (lim_c)
  );

  always_comb begin
    nxt_s = $signed({{(NXT_W-FLIGHT_W){1'b0}}, inflight_q})
          + $signed({{(NXT_W-AVAIL_W){1'b0}}, adm_c})
          - $signed({{(NXT_W-AVAIL_W){1'b0}}, disp_all});
    if (nxt_s[NXT_W-1]) inflight_nxt = '0;
    else                inflight_nxt = nxt_s[FLIGHT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q      <= '0;
      rob_empty   <= 1'b1;
      inflight_q  <= '0;
      adm_cnt     <= '0;
      block_req   <= 1'b0;
      full_reason <= '0;
    end else begin
      for (int r = 0; r < NUM_RES; r++) begin
        if (rpt_vld[r]) free_q[r] <= rpt_val[r];
      end
      if (rob_free_vld) rob_empty <= rob_empty_in;
      inflight_q  <= inflight_nxt;
      adm_cnt     <= adm_c;
      block_req   <= blk_c;
      full_reason <= lim_c ? min_onehot : 3'b000;
    end
  end

  assign rob_full_evt = evt_cnt[RES_ROB];
  assign iq_full_evt  = evt_cnt[RES_IQ];
  assign lsq_full_evt = evt_cnt[RES_LSQ];
endmodule

// File: rtl/dcl_checker.sv
module dcl_checker #(
  parameter int FREE_W   = 6,
  parameter int FLIGHT_W = 7,
  parameter int AVAIL_W  = 4,
  parameter int PREG_W   = 8,
  parameter int DEST_W   = 2,
  parameter int EVT_W    = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [AVAIL_W-1:0] avail_cnt,
  input logic [AVAIL_W-1:0] rename_width,
  input logic [PREG_W-1:0]  free_pregs,
  input logic [DEST_W-1:0]  head_dests,
  input logic [AVAIL_W-1:0] adm_cnt,
  input logic               block_req,
  input logic [2:0]         full_reason,
  input logic [EVT_W-1:0]   rob_full_evt,
  input logic [EVT_W-1:0]   iq_full_evt,
  input logic [EVT_W-1:0]   lsq_full_evt
);
  logic [PREG_W-1:0] dests_ext;
  assign dests_ext = {{(PREG_W-DEST_W){1'b0}}, head_dests};

  p_adm_le_avail_r6: assert property (@(posedge clk) disable iff (rst)
    adm_cnt <= $past(avail_cnt));

  p_width_cap_r7: assert property (@(posedge clk) disable iff (rst)
    adm_cnt <= $past(rename_width));

  p_leftover_block_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && (adm_cnt < $past(avail_cnt))) |-> block_req);

  p_reason_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(full_reason));

  p_reason_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    (full_reason != 3'b000) |-> block_req);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ($past(avail_cnt) == '0)) |->
      ((adm_cnt == '0) && !block_req && (full_reason == 3'b000)));

  p_preg_stall_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ($past(avail_cnt) != '0) && ($past(free_pregs) < $past(dests_ext)))
      |-> ((adm_cnt == '0) && block_req));

  p_evt_mono_r11: assert property (@(posedge clk) disable iff (rst)
    (rob_full_evt >= $past(rob_full_evt)) && (iq_full_evt >= $past(iq_full_evt))
      && (lsq_full_evt >= $past(lsq_full_evt)));
endmodule

bind dispatch_credit_limiter dcl_checker #(
  .FREE_W(FREE_W), .FLIGHT_W(FLIGHT_W), .AVAIL_W(AVAIL_W),
  .PREG_W(PREG_W), .DEST_W(DEST_W), .EVT_W(EVT_W)
) u_chk (.*);

// File: tb/sim_dispatch_credit_limiter.sv
module sim_dispatch_credit_limiter;
  localparam int CLK_PERIOD = 10;
  localparam int FREE_W   = 5;
  localparam int FLIGHT_W = 6;
  localparam int AVAIL_W  = 4;
  localparam int PREG_W   = 4;
  localparam int DEST_W   = 2;
  localparam int EVT_W    = 3;
  localparam int EVT_MAX  = (1 << EVT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [FREE_W-1:0]  rob_free_in = '0, iq_free_in = '0, lsq_free_in = '0;
  logic rob_free_vld = 1'b0, iq_free_vld = 1'b0, lsq_free_vld = 1'b0, rob_empty_in = 1'b0;
  logic [AVAIL_W-1:0] disp_all = '0, disp_lsq = '0, avail_cnt = '0, rename_width = '0;
  logic [PREG_W-1:0]  free_pregs = '0;
  logic [DEST_W-1:0]  head_dests = '0;
  logic [AVAIL_W-1:0] adm_cnt;
  logic               block_req, rob_empty;
  logic [2:0]         full_reason;
  logic [EVT_W-1:0]   rob_full_evt, iq_full_evt, lsq_full_evt;

  always #(CLK_PERIOD/2) clk = ~clk;

  dispatch_credit_limiter #(
    .FREE_W(FREE_W), .FLIGHT_W(FLIGHT_W), .AVAIL_W(AVAIL_W),
    .PREG_W(PREG_W), .DEST_W(DEST_W), .EVT_W(EVT_W)
  ) u0 (.*);

  int n_chk = 0;
  int n_err = 0;

  // behavioural reference state
  int m_free[3];
  int m_inflight;
  int m_evt[3];
  bit m_rob_empty;
  int e_adm, e_rsn;
  bit e_blk;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    int cr[3];
    int mn, src, n;
    bit lim;
    cr[0] = m_free[0] - (m_inflight - int'(disp_all));
    cr[1] = m_free[1] - (m_inflight - int'(disp_all));
    cr[2] = m_free[2] - (m_inflight - int'(disp_lsq));
    mn = cr[0]; src = 0;
    if (cr[1] < mn) begin mn = cr[1]; src = 1; end
    if (cr[2] < mn) begin mn = cr[2]; src = 2; end
    e_adm = 0; e_blk = 0; e_rsn = 0; lim = 0; n = 0;
    if (avail_cnt != 0) begin
      if (mn <= 0) lim = 1;
      else begin
        n = int'(avail_cnt);
        if (mn < n) begin n = mn; lim = 1; end
        if (n > int'(rename_width)) n = int'(rename_width);
      end
      if (int'(free_pregs) < int'(head_dests)) n = 0;
      if (lim || n < int'(avail_cnt)) e_blk = 1;
      e_adm = n;
      if (lim) begin
        e_rsn = 1 << src;
        if (m_evt[src] < EVT_MAX) m_evt[src]++;
      end
    end
    m_inflight = m_inflight + e_adm - int'(disp_all);
    if (m_inflight < 0) m_inflight = 0;
    if (rob_free_vld) begin m_free[0] = int'(rob_free_in); m_rob_empty = rob_empty_in; end
    if (iq_free_vld)  m_free[1] = int'(iq_free_in);
    if (lsq_free_vld) m_free[2] = int'(lsq_free_in);
  endtask

  // one clock: model evaluates at the edge, outputs compared at the falling edge (R12)
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R6", "admitted", int'(adm_cnt), e_adm);
    chk("R7", "block", int'(block_req), int'(e_blk));
    chk("R4", "reason", int'(full_reason), e_rsn);
    chk("R11", "rob events", int'(rob_full_evt), m_evt[0]);
    chk("R11", "iq events", int'(iq_full_evt), m_evt[1]);
    chk("R11", "lsq events", int'(lsq_full_evt), m_evt[2]);
    chk("R2", "rob empty", int'(rob_empty), int'(m_rob_empty));
  endtask

  task automatic drv(int av, int wd, int pr, int hd, int da, int dl);
    avail_cnt = AVAIL_W'(av); rename_width = AVAIL_W'(wd);
    free_pregs = PREG_W'(pr); head_dests = DEST_W'(hd);
    disp_all = AVAIL_W'(da); disp_lsq = AVAIL_W'(dl);
    rob_free_vld = 1'b0; iq_free_vld = 1'b0; lsq_free_vld = 1'b0;
  endtask

  task automatic rpt(bit rv, int r, bit re, bit iv, int i, bit lv, int l);
    rob_free_vld = rv; rob_free_in = FREE_W'(r); rob_empty_in = re;
    iq_free_vld = iv; iq_free_in = FREE_W'(i);
    lsq_free_vld = lv; lsq_free_in = FREE_W'(l);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R12: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin m_free[k] = 0; m_evt[k] = 0; end
    m_inflight = 0; m_rob_empty = 1'b1;
    // R1: reset state
    chk("R1", "admitted", int'(adm_cnt), 0);
    chk("R1", "block", int'(block_req), 0);
    chk("R1", "reason", int'(full_reason), 0);
    chk("R1", "events", int'(rob_full_evt) + int'(iq_full_evt) + int'(lsq_full_evt), 0);
    chk("R1", "rob empty", int'(rob_empty), 1);

    // R5 + R4 tie: all stored counts zero -> credits tie at 0, reorder buffer named
    drv(4, 4, 15, 1, 0, 0); cyc();
    chk("R5", "zero credit admits nothing", int'(adm_cnt), 0);
    chk("R4", "tie goes to rob", int'(full_reason), 1);

    // R10 + R2: reports land, nothing waiting
    drv(0, 4, 15, 1, 0, 0); rpt(1, 10, 0, 1, 8, 1, 12); cyc();
    chk("R10", "idle block", int'(block_req), 0);
    chk("R2", "empty flag loaded", int'(rob_empty), 0);

    // R3/R12: credits 10,8,12 -> all 3 admitted one edge later
    drv(3, 4, 15, 1, 0, 0); cyc();
    chk("R12", "admitted next edge", int'(adm_cnt), 3);

    // R6/R7: credits 7,5,9, six waiting -> capped 5 by iq, then width 4
    drv(6, 4, 15, 1, 0, 0); cyc();
    chk("R7", "width cap", int'(adm_cnt), 4);
    chk("R4", "iq limits", int'(full_reason), 2);

    // R2: iq value offered without strobe ignored; lsq load used only next cycle
    drv(5, 8, 15, 1, 2, 0); rpt(0, 0, 0, 0, 0, 1, 9); cyc();
    chk("R2", "unstrobed report ignored", int'(adm_cnt), 3);

    // R3: lsq credit uses its own dispatch count -> 9-(8-0)=1
    drv(5, 8, 15, 1, 4, 0); cyc();
    chk("R3", "lsq credit", int'(adm_cnt), 1);
    chk("R4", "lsq limits", int'(full_reason), 4);

    // R8: register starvation
    drv(2, 8, 0, 2, 0, 0); cyc();
    chk("R8", "preg stall admitted", int'(adm_cnt), 0);
    chk("R8", "preg stall block", int'(block_req), 1);

    // R4 tie rob vs iq at credit 3
    drv(0, 8, 15, 1, 0, 0); rpt(1, 8, 0, 1, 8, 0, 0); cyc();
    drv(4, 8, 15, 1, 0, 0); cyc();
    chk("R4", "rob wins tie with iq", int'(full_reason), 1);
    chk("R6", "capped at tie credit", int'(adm_cnt), 3);

    // R5: negative credit
    drv(0, 8, 15, 1, 0, 0); rpt(1, 2, 1, 0, 0, 0, 0); cyc();
    drv(1, 8, 15, 1, 0, 0); cyc();
    chk("R5", "negative credit", int'(adm_cnt), 0);
    for (int k = 0; k < 6; k++) cyc();
    chk("R11", "rob counter saturates", int'(rob_full_evt), EVT_MAX);

    // R9: drain in-flight, then credits back to full report
    drv(0, 8, 15, 1, 8, 8); rpt(1, 10, 1, 1, 10, 1, 10); cyc();
    drv(15, 15, 15, 1, 0, 0); cyc();
    chk("R9", "in-flight drained", int'(adm_cnt), 10);
    drv(0, 15, 15, 1, 15, 15); cyc();
    drv(15, 15, 15, 1, 0, 0); cyc();
    chk("R9", "in-flight floored at zero", int'(adm_cnt), 10);

    // random phase, dispatch never beyond in-flight
    for (int t = 0; t < 3000; t++) begin
      int lim_d;
      lim_d = (m_inflight > 15) ? 15 : m_inflight;
      drv($urandom_range(15), $urandom_range(15, 1), $urandom_range(15),
          $urandom_range(3), $urandom_range(lim_d), $urandom_range(lim_d));
      rpt($urandom_range(3) == 0, $urandom_range(31), $urandom_range(1),
          $urandom_range(3) == 0, $urandom_range(31),
          $urandom_range(3) == 0, $urandom_range(31));
      cyc();
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule